// File: doc/BRIEF.md
# Indirect Context Record Access Engine

This block gives software access to per-queue context records held in an internal RAM. The records are reached only through a small register window, never through a direct memory map. Software fills a data window and a per-bit mask window, each several 32-bit words long. It then writes a command word that names a context type, a record index and an operation. The engine clears, updates under the mask, or reads the selected record. While the command runs, it raises a busy flag that software polls.

There is one record for each pair of context type and index. The context types are the descriptor, hardware-state and credit contexts for each transfer direction, plus the prefetch, function-map and interrupt-coalescing contexts. A field inside a record is located by absolute bit positions and may cross up to two 32-bit word boundaries. The per-bit mask lets software change such a field without disturbing its neighbours. A command that arrives while the engine is busy, or that is malformed, is dropped and sets a sticky error flag.

Top module: `ctx_access_engine`

## Requirements
- R1: After reset, every data window word, every mask window word and the command register read as zero.
- R2: The register map uses word addresses. Addresses 0 to 3 hold data window words 0 to 3 and addresses 4 to 7 hold mask window words 0 to 3; each of these reads back the last value written to it. Reads of addresses 9 to 15 return zero, and writes to them change nothing.
- R3: The command word holds the record index in bits [7:0], the operation in bits [9:8] (1 clear, 2 masked write, 3 read) and the context type in bits [15:12] (legal values 0 to 8). Reading address 8 returns the fields of the last accepted command in the same positions, with busy in bit 31 and the error flag in bit 30.
- R4: For a masked write, each record bit whose mask bit is 1 takes the data window bit, and every other bit keeps its old value. Busy reads 1 for exactly three cycles after the clock edge that accepts the command.
- R5: A read copies the whole record into the data window. The window changes on the same edge at which busy falls. Busy reads 1 for exactly two cycles after the accepting edge.
- R6: A clear sets every bit of the record to zero, whatever the mask holds. It leaves the data window unchanged and keeps busy high for three cycles.
- R7: A field that spans three consecutive words, selected only by mask bits 20 through 90 of the record, is updated exactly; every bit outside that span keeps its value.
- R8: Each of the 9 context types has 16 independent records. A command on one type or index leaves every other record unchanged, and the highest type (8) and highest index (15) can be used.
- R9: A command written while busy is 1 is ignored. The echoed fields, the target record and the data window stay as they were, and the error flag becomes 1.
- R10: A command with operation 0, a type above 8 or an index above 15 is rejected. Busy stays 0 and the error flag becomes 1.
- R11: The error flag stays 1 until reset, and reset clears it. Reset leaves the stored records unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Word address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, taken combinationally from the current state |

## Verification
The read data follows the register state with no delay, so each register result can be seen one edge after the write that causes it. A masked write or a clear keeps busy high for three samples after its accepting edge, and a read keeps it high for two. The refreshed data window appears in the same sample in which busy is first seen low. After every rising edge the bench waits a short settling delay, then compares the read data with a behavioural model that steps in the same edge order. The explicit checks count busy samples one cycle at a time against those figures, and they read records back only after busy has fallen.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  // Operation codes carried in command bits [9:8]
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } ctx_op_e;

  // Context kinds, selected by command bits [15:12]
  typedef enum logic [3:0] {
    CT_DESC_TX   = 4'd0,
    CT_DESC_RX   = 4'd1,
    CT_HWST_TX   = 4'd2,
    CT_HWST_RX   = 4'd3,
    CT_CREDIT_TX = 4'd4,
    CT_CREDIT_RX = 4'd5,
    CT_PREFETCH  = 4'd6,
    CT_FUNC_MAP  = 4'd7,
    CT_IRQ_COAL  = 4'd8
  } ctx_kind_e;

  typedef struct packed {
    logic [3:0] ctype;
    ctx_op_e    op;
    logic [7:0] idx;
  } ctx_cmd_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_STORE = 2'd2,
    SQ_DONE  = 2'd3
  } seq_state_e;

  function automatic ctx_cmd_t unpack_cmd(input logic [31:0] w);
    ctx_cmd_t c;
    c.idx   = w[7:0];
    c.op    = ctx_op_e'(w[9:8]);
    c.ctype = w[15:12];
    return c;
  endfunction

  function automatic logic [31:0] pack_status(input ctx_cmd_t c, input logic bsy,
                                              input logic fault);
    logic [31:0] w;
    w        = '0;
    w[7:0]   = c.idx;
    w[9:8]   = c.op;
    w[15:12] = c.ctype;
    w[30]    = fault;
    w[31]    = bsy;
    return w;
  endfunction

endpackage

// File: rtl/ctx_window.sv
module ctx_window #(
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  input  logic                        load,
  input  logic [NUM_WORDS-1:0][31:0]  load_rec,
  output logic [NUM_WORDS-1:0][31:0]  data_win,
  output logic [NUM_WORDS-1:0][31:0]  mask_win
);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(w);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(NUM_WORDS + w);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_win[w] <= '0;
        mask_win[w] <= '0;
      end else begin
        // record load from a read command wins over a bus write
        if (load)
          data_win[w] <= load_rec[w];
        else if (bus_wr && bus_addr == DATA_A)
          data_win[w] <= bus_wdata;
        if (bus_wr && bus_addr == MASK_A)
          mask_win[w] <= bus_wdata;
      end
    end
  end

  // R5
  win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (data_win == $past(load_rec)));

endmodule

// File: rtl/ctx_store.sv
module ctx_store #(
  parameter int NUM_WORDS = 4,
  parameter int DEPTH     = 144,
  parameter int AW        = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic                        wr_en,
  input  logic [AW-1:0]               addr,
  input  logic [NUM_WORDS-1:0][31:0]  wdata,
  output logic [NUM_WORDS-1:0][31:0]  rdata
);

  logic [NUM_WORDS-1:0][31:0] mem [DEPTH];

  // storage is not reset: records survive a reset of the control logic
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= mem[addr];
  end

  // R4
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  // R8
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> (32'(addr) < 32'(DEPTH)));

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int NUM_IDX   = 16,
  parameter int NUM_TYPES = 9,
  parameter int RAM_AW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_wr,
  input  ctx_cmd_t                    cmd_in,
  input  logic [NUM_WORDS-1:0][31:0]  data_win,
  input  logic [NUM_WORDS-1:0][31:0]  mask_win,
  input  logic [NUM_WORDS-1:0][31:0]  ram_rdata,
  output logic                        ram_rd,
  output logic                        ram_wr,
  output logic [RAM_AW-1:0]           ram_addr,
  output logic [NUM_WORDS-1:0][31:0]  ram_wdata,
  output logic                        win_load,
  output logic                        busy,
  output logic                        err,
  output ctx_cmd_t                    cur_cmd
);

  function automatic logic cmd_legal(input ctx_cmd_t c);
    return (c.op != OP_NONE) && (32'(c.ctype) < 32'(NUM_TYPES))
        && (32'(c.idx) < 32'(NUM_IDX));
  endfunction

  function automatic logic [RAM_AW-1:0] rec_slot(input logic [3:0] t, input logic [7:0] i);
    return RAM_AW'(32'(t) * 32'(NUM_IDX) + 32'(i));
  endfunction

  function automatic logic [NUM_WORDS-1:0][31:0] merge_rec(
      input logic [NUM_WORDS-1:0][31:0] old_r,
      input logic [NUM_WORDS-1:0][31:0] new_r,
      input logic [NUM_WORDS-1:0][31:0] sel_m);
    return (old_r & ~sel_m) | (new_r & sel_m);
  endfunction

  seq_state_e state;
  logic       cmd_start;
  logic       cmd_reject;

  assign busy       = (state != SQ_IDLE);
  assign cmd_start  = cmd_wr && !busy && cmd_legal(cmd_in);
  assign cmd_reject = cmd_wr && (busy || !cmd_legal(cmd_in));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cur_cmd <= '0;
      err     <= 1'b0;
    end else begin
      if (cmd_reject) err <= 1'b1;
      unique case (state)
        SQ_IDLE:  if (cmd_start) begin
                    cur_cmd <= cmd_in;
                    state   <= SQ_FETCH;
                  end
        SQ_FETCH: state <= (cur_cmd.op == OP_READ) ? SQ_DONE : SQ_STORE;
        SQ_STORE: state <= SQ_DONE;
        SQ_DONE:  state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  assign ram_addr  = rec_slot(cur_cmd.ctype, cur_cmd.idx);
  assign ram_rd    = (state == SQ_FETCH);
  assign ram_wr    = (state == SQ_STORE);
  assign ram_wdata = (cur_cmd.op == OP_CLEAR) ? '0
                   : merge_rec(ram_rdata, data_win, mask_win);
  assign win_load  = (state == SQ_DONE) && (cur_cmd.op == OP_READ);

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> busy);

  // R9
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> (err && cur_cmd == $past(cur_cmd)));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/ctx_access_engine.sv
module ctx_access_engine
  import ctx_pkg::*;
#(
  parameter  int NUM_WORDS = 4,
  parameter  int NUM_IDX   = 16,
  parameter  int NUM_TYPES = 9,
  localparam int ADDR_W    = $clog2(2 * NUM_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam int DEPTH  = NUM_TYPES * NUM_IDX;
  localparam int RAM_AW = $clog2(DEPTH);
  localparam int WSEL_W = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(2 * NUM_WORDS);

  logic [NUM_WORDS-1:0][31:0] data_win, mask_win, ram_rdata, ram_wdata;
  logic                       ram_rd, ram_wr, win_load, busy, err, cmd_wr;
  logic [RAM_AW-1:0]          ram_addr;
  ctx_cmd_t                   cmd_in, cur_cmd;

  assign cmd_wr = reg_wr && (reg_addr == CMD_ADDR);
  assign cmd_in = unpack_cmd(reg_wdata);

  ctx_window #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_window (
    .clk(clk), .rst_n(rst_n), .bus_wr(reg_wr), .bus_addr(reg_addr),
    .bus_wdata(reg_wdata), .load(win_load), .load_rec(ram_rdata),
    .data_win(data_win), .mask_win(mask_win));

  ctx_seq #(.NUM_WORDS(NUM_WORDS), .NUM_IDX(NUM_IDX), .NUM_TYPES(NUM_TYPES),
            .RAM_AW(RAM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
    .data_win(data_win), .mask_win(mask_win), .ram_rdata(ram_rdata),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .win_load(win_load), .busy(busy), .err(err), .cur_cmd(cur_cmd));

  ctx_store #(.NUM_WORDS(NUM_WORDS), .DEPTH(DEPTH), .AW(RAM_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_en(ram_rd), .wr_en(ram_wr), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata));

  always_comb begin
    reg_rdata = '0;
    if (32'(reg_addr) < 32'(NUM_WORDS))
      reg_rdata = data_win[reg_addr[WSEL_W-1:0]];
    else if (32'(reg_addr) < 32'(2 * NUM_WORDS))
      reg_rdata = mask_win[reg_addr[WSEL_W-1:0]];
    else if (reg_addr == CMD_ADDR)
      reg_rdata = pack_status(cur_cmd, busy, err);
  end

  // R5
  read_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_cmd.op == OP_READ) |-> !ram_wr);

endmodule

// File: tb/sim_ctx_access_engine.sv
module sim_ctx_access_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  ctx_access_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #2.5ns clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_data [4];
  logic [31:0] m_mask [4];
  logic [31:0] m_mem [int];
  int          m_left;
  int          m_slot;
  logic [1:0]  m_pop;
  logic        m_err;
  logic [7:0]  m_idx;
  logic [1:0]  m_op;
  logic [3:0]  m_type;

  task automatic model_reset();
    for (int w = 0; w < 4; w++) begin m_data[w] = '0; m_mask[w] = '0; end
    m_left = 0; m_err = 0; m_idx = '0; m_op = '0; m_type = '0; m_pop = '0; m_slot = 0;
  endtask

  function automatic logic [31:0] model_val(input int a);
    if (a < 4) return m_data[a];
    if (a < 8) return m_mask[a-4];
    if (a == 8) return {(m_left > 0) ? 1'b1 : 1'b0, m_err, 14'd0, m_type, 2'b00, m_op, m_idx};
    return 32'd0;
  endfunction

  task automatic model_step(input bit w, input int a, input logic [31:0] d);
    bit pre_busy;
    int op, ty, ix, key;
    logic [31:0] old, nw;
    pre_busy = (m_left > 0);
    if (w && a < 4) m_data[a] = d;
    if (w && a >= 4 && a < 8) m_mask[a-4] = d;
    if (m_left > 0) begin
      m_left--;
      if (m_left == 0 && m_pop == 2'd3)
        for (int k = 0; k < 4; k++) m_data[k] = m_mem[m_slot*4 + k];
    end
    if (w && a == 8) begin
      op = int'(d[9:8]); ty = int'(d[15:12]); ix = int'(d[7:0]);
      if (pre_busy || op == 0 || ty > 8 || ix > 15) m_err = 1'b1;
      else begin
        m_idx = d[7:0]; m_op = d[9:8]; m_type = d[15:12];
        m_pop = d[9:8]; m_slot = ty*16 + ix;
        m_left = (op == 3) ? 2 : 3;
        for (int k = 0; k < 4; k++) begin
          key = m_slot*4 + k;
          if (op == 1) m_mem[key] = '0;
          else if (op == 2) begin
            old = m_mem.exists(key) ? m_mem[key] : 'x;
            for (int b = 0; b < 32; b++) nw[b] = m_mask[k][b] ? m_data[k][b] : old[b];
            m_mem[key] = nw;
          end
        end
      end
    end
  endtask

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = w; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk);
    #1ns;
    model_step(w, a, d);
    chk((a == 8) ? "R3" : "R2", reg_rdata, model_val(a), "per-cycle model compare");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  function automatic logic [31:0] cword(input int op, input int ty, input int ix);
    return {16'd0, 4'(ty), 2'b00, 2'(op), 8'(ix)};
  endfunction

  task automatic run_cmd(input int op, input int ty, input int ix, output int n);
    cyc(1, 8, cword(op, ty, ix));
    n = 0;
    while (reg_rdata[31] === 1'b1 && n < 10) begin cyc(0, 8, 32'd0); n++; end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    cyc(0, a, 32'd0);
    v = reg_rdata;
  endtask

  task automatic set_win(input logic [127:0] dv, input logic [127:0] mv);
    for (int w = 0; w < 4; w++) cyc(1, w, dv[w*32 +: 32]);
    for (int w = 0; w < 4; w++) cyc(1, 4 + w, mv[w*32 +: 32]);
  endtask

  task automatic read_rec(input int ty, input int ix, input string req, output logic [127:0] r);
    int n;
    logic [31:0] v;
    run_cmd(3, ty, ix, n);
    chk(req, 32'(n), 32'd2, "read busy cycles");
    for (int w = 0; w < 4; w++) begin rd(w, v); r[w*32 +: 32] = v; end
  endtask

  task automatic chk_rec(input string req, input logic [127:0] act, input logic [127:0] exp,
                         input string what);
    for (int w = 0; w < 4; w++) chk(req, act[w*32 +: 32], exp[w*32 +: 32], what);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [127:0] pa, pb, pe, pf, pg, spanm, exp, got, junk;
    logic [31:0]  v;
    int n;
    model_reset();
    do_reset();

    // R1: reset state
    for (int a = 0; a < 9; a++) begin rd(a, v); chk("R1", v, 32'd0, "reset value"); end

    // R2: window read-back and unmapped addresses
    cyc(1, 2, 32'hCAFE_0002);
    cyc(1, 5, 32'h5A5A_0005);
    cyc(1, 12, 32'hFFFF_FFFF);
    rd(12, v); chk("R2", v, 32'd0, "unmapped read");
    rd(2, v);  chk("R2", v, 32'hCAFE_0002, "data word read-back");
    rd(5, v);  chk("R2", v, 32'h5A5A_0005, "mask word read-back");

    // R6: clear with timing; R4: full-mask write timing
    run_cmd(1, 0, 3, n); chk("R6", 32'(n), 32'd3, "clear busy cycles");
    pa = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    set_win(pa, {128{1'b1}});
    run_cmd(2, 0, 3, n); chk("R4", 32'(n), 32'd3, "write busy cycles");
    set_win(128'd0, {128{1'b1}});
    read_rec(0, 3, "R5", got); chk_rec("R5", got, pa, "read after full write");
    rd(8, v); chk("R3", v, cword(3, 0, 3), "command echo");

    // R4: partial mask merge
    pb = 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000_9999;
    set_win(pb, {4{32'hFFFF_0000}});
    run_cmd(2, 0, 3, n);
    read_rec(0, 3, "R4", got);
    for (int b = 0; b < 128; b++) exp[b] = (b % 32 >= 16) ? pb[b] : pa[b];
    chk_rec("R4", got, exp, "masked merge");

    // R7: field spanning three words (bits 20..90)
    pa = exp;
    spanm = ((128'd1 << 71) - 128'd1) << 20;
    set_win(~pa, spanm);
    run_cmd(2, 0, 3, n);
    read_rec(0, 3, "R7", got);
    for (int b = 0; b < 128; b++) exp[b] = (b >= 20 && b <= 90) ? ~pa[b] : pa[b];
    chk_rec("R7", got, exp, "three-word field");

    // R6: clear ignores mask and leaves window alone
    junk = 128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0;
    set_win(junk, 128'd0);
    run_cmd(1, 0, 3, n); chk("R6", 32'(n), 32'd3, "clear busy cycles");
    for (int w = 0; w < 4; w++) begin rd(w, v); chk("R6", v, junk[w*32 +: 32], "window kept"); end
    read_rec(0, 3, "R6", got); chk_rec("R6", got, 128'd0, "record cleared");

    // R8: isolation at the top type and top index
    pe = 128'hE0E0_E1E1_E2E2_E3E3_E4E4_E5E5_E6E6_E7E7;
    pf = 128'hF0F0_F1F1_F2F2_F3F3_F4F4_F5F5_F6F6_F7F7;
    set_win(pe, {128{1'b1}}); run_cmd(2, 8, 15, n);
    set_win(pf, {128{1'b1}}); run_cmd(2, 0, 15, n);
    read_rec(8, 15, "R8", got); chk_rec("R8", got, pe, "top type record");
    read_rec(0, 15, "R8", got); chk_rec("R8", got, pf, "same index other type");
    read_rec(0, 3, "R8", got);  chk_rec("R8", got, 128'd0, "other index untouched");

    // R10: malformed commands
    run_cmd(0, 0, 3, n); chk("R10", 32'(n), 32'd0, "op 0 no busy");
    rd(8, v); chk("R10", v, 32'h4000_0000 | cword(3, 0, 3), "op 0 sets error");
    // R11: sticky, cleared by reset, storage kept
    run_cmd(1, 0, 3, n);
    rd(8, v); chk("R11", {31'd0, v[30]}, 32'd1, "error sticky");
    do_reset();
    rd(8, v); chk("R11", v, 32'd0, "reset clears error");
    read_rec(8, 15, "R11", got); chk_rec("R11", got, pe, "record survives reset");
    do_reset();
    run_cmd(1, 9, 0, n); chk("R10", 32'(n), 32'd0, "type 9 no busy");
    rd(8, v); chk("R10", v, 32'h4000_0000, "type 9 error");
    do_reset();
    run_cmd(1, 0, 16, n); chk("R10", 32'(n), 32'd0, "index 16 no busy");
    rd(8, v); chk("R10", v, 32'h4000_0000, "index 16 error");
    do_reset();

    // R9: command while busy
    pg = 128'h0101_0202_0303_0404_0505_0606_0707_0808;
    set_win(pg, {128{1'b1}});
    cyc(1, 8, cword(2, 0, 15));
    cyc(1, 8, cword(3, 8, 15));
    n = 0;
    while (reg_rdata[31] === 1'b1 && n < 10) begin cyc(0, 8, 32'd0); n++; end
    rd(8, v); chk("R9", v, 32'h4000_0000 | cword(2, 0, 15), "echo kept, error set");
    for (int w = 0; w < 4; w++) begin rd(w, v); chk("R9", v, pg[w*32 +: 32], "window not loaded"); end
    read_rec(0, 15, "R9", got); chk_rec("R9", got, pg, "first command done");
    rd(8, v); chk("R11", {31'd0, v[30]}, 32'd1, "error still set");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1-watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule